// File: doc/BRIEF.md
# Privilege-Gated Event Count Register

This block holds a 32-bit event counter that lives in a system-control coprocessor register space. A request on the register port carries four select fields: a primary register number, a secondary register number and two opcode fields. The request also carries a read/write flag, write data and the privilege level of the requester. The counter adds one on every cycle in which its event input is high. It can also be loaded by a permitted write, or zeroed by a clear command from the performance-monitor control logic.

Privileged requests are always served, from the secure world and from the non-secure world alike, so the world needs no port. A user-mode request is served only when the user-access enable input is 1. When that enable is 0, the block refuses the request. It raises an undefined-instruction flag, returns zero data and leaves the counter as it was. Every request that hits the register gets its response in the cycle after the request. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `priv_event_counter`

## Requirements
- R1: The register is selected only when the primary register field is 15, the secondary register field is 12, the first opcode field is 0 and the second opcode field is 3. A request with any other select value gets no response, raises no flag and does not change the counter.
- R2: A privileged read (req_priv=1) returns the counter value as it was in the request cycle, whatever the user-access enable is.
- R3: A privileged write loads the write data into the counter. The new value is visible from the next cycle.
- R4: A user-mode request (req_priv=0) with user_en=1 reads and writes the counter just as a privileged request does.
- R5: A user-mode read with user_en=0 sets rsp_undef and returns rsp_rdata=0.
- R6: A user-mode write with user_en=0 sets rsp_undef and leaves the counter unchanged.
- R7: After reset the counter is 0 and all response outputs are 0.
- R8: Each cycle with evt_in high adds one to the counter, and the counter wraps from 0xFFFFFFFF to 0.
- R9: A cycle with clr_in high sets the counter to 0.
- R10: A clear takes precedence over a write in the same cycle, and a permitted write takes precedence over an event in the same cycle.
- R11: rsp_valid is 1 in exactly the cycle after a request that hits the register. In every other cycle rsp_valid, rsp_undef and rsp_rdata are 0, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_crn | input | 4 | Primary register select |
| req_op1 | input | 3 | First opcode field |
| req_crm | input | 4 | Secondary register select |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 for a privileged requester, 0 for user mode |
| user_en | input | 1 | Enables user-mode access |
| evt_in | input | 1 | Event to count |
| clr_in | input | 1 | Clear from the performance-monitor control logic |
| rsp_valid | output | 1 | Response for a request that hit the register |
| rsp_rdata | output | 32 | Read data, or 0 when refused or for a write |
| rsp_undef | output | 1 | Undefined-instruction indication |

## Verification
The counter value can only be seen through read responses. A wrong count, a lost write or an update that a refused request slips through therefore shows up on rsp_rdata at the next permitted read, one cycle after that read is issued. The bench reads often, so a corrupted count shows up within a few cycles of the mistake. A wrong permission or decode decision shows up at once, in the response cycle, as a wrong rsp_valid or rsp_undef value. The bench's reference model is compared with all three outputs on every clock, so none of these errors can go unnoticed for long.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef struct packed {
    logic [3:0] crn;
    logic [2:0] op1;
    logic [3:0] crm;
    logic [2:0] op2;
  } sel_t;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } mode_e;
endpackage

// File: rtl/pec_decode.sv
module pec_decode
  import pec_pkg::*;
#(
  parameter logic [3:0] MATCH_CRN = 4'd15,
  parameter logic [2:0] MATCH_OP1 = 3'd0,
  parameter logic [3:0] MATCH_CRM = 4'd12,
  parameter logic [2:0] MATCH_OP2 = 3'd3
) (
  input  logic req_valid,
  input  sel_t sel,
  output logic hit
);
  localparam sel_t MATCH = '{crn: MATCH_CRN, op1: MATCH_OP1,
                             crm: MATCH_CRM, op2: MATCH_OP2};

  always_comb begin
    hit = req_valid && (sel == MATCH);
  end
endmodule

// File: rtl/pec_access_check.sv
module pec_access_check
  import pec_pkg::*;
(
  input  logic  hit,
  input  logic  is_write,
  input  mode_e mode,
  input  logic  user_en,
  output logic  grant_rd,
  output logic  grant_wr,
  output logic  deny
);
  logic allowed;

  always_comb begin
    allowed  = (mode == MODE_PRIV) || user_en;
    grant_rd = hit && allowed && !is_write;
    grant_wr = hit && allowed && is_write;
    deny     = hit && !allowed;
  end
endmodule

// File: rtl/pec_count_core.sv
module pec_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr || wr_en || evt;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = wr_data;
    else            cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R10
  write_beats_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (cnt == $past(wr_data)));
  // R8
  event_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_en && !clr) |=> (cnt == $past(cnt) + ONE));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !wr_en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/priv_event_counter.sv
module priv_event_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_crn,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [CNT_W-1:0] req_wdata,
  input  logic             req_priv,
  input  logic             user_en,
  input  logic             evt_in,
  input  logic             clr_in,
  output logic             rsp_valid,
  output logic [CNT_W-1:0] rsp_rdata,
  output logic             rsp_undef
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sel_t  sel;
  mode_e mode;
  logic  hit, grant_rd, grant_wr, deny;
  logic [CNT_W-1:0] cnt;

  assign sel  = '{crn: req_crn, op1: req_op1, crm: req_crm, op2: req_op2};
  assign mode = req_priv ? MODE_PRIV : MODE_USER;

  pec_decode u_decode (
    .req_valid (req_valid),
    .sel       (sel),
    .hit       (hit)
  );

  pec_access_check u_access (
    .hit      (hit),
    .is_write (req_write),
    .mode     (mode),
    .user_en  (user_en),
    .grant_rd (grant_rd),
    .grant_wr (grant_wr),
    .deny     (deny)
  );

  pec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (clr_in),
    .wr_en   (grant_wr),
    .wr_data (req_wdata),
    .evt     (evt_in),
    .cnt     (cnt)
  );

  // response stage
  logic             valid_d, undef_d;
  logic [CNT_W-1:0] rdata_d;

  always_comb begin
    valid_d = hit;
    undef_d = deny;
    rdata_d = grant_rd ? cnt : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_undef <= undef_d;
      rsp_rdata <= rdata_d;
    end
  end

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $past(req_valid));
  // R5
  refused_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_undef |-> (rsp_valid && rsp_rdata == '0));
  // R5
  undef_only_user_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_undef |-> ($past(!req_priv) && $past(!user_en)));
  // R6
  refused_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (deny && req_write && !evt_in && !clr_in) |=> $stable(cnt));
endmodule

// File: tb/tb_priv_event_counter.sv
`timescale 1ns/1ps
module tb_priv_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_priv = 0, user_en = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0;
  logic [31:0] req_wdata = 0;
  logic        evt_in = 0, clr_in = 0;
  logic        rsp_valid, rsp_undef;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0;
  string tag = "R7";
  bit done = 0;

  always #4 clk = ~clk;

  priv_event_counter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_crn(req_crn), .req_op1(req_op1), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .req_priv(req_priv), .user_en(user_en),
    .evt_in(evt_in), .clr_in(clr_in), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef)
  );

  // behavioural reference model
  logic [31:0] m_cnt = 0, e_rdata = 0;
  logic        e_valid = 0, e_undef = 0;

  always @(posedge clk) begin
    bit sel_ok, ok;
    if (!rst_n) begin
      m_cnt = 0; e_valid = 0; e_undef = 0; e_rdata = 0;
    end else begin
      sel_ok  = req_valid && req_crn == 15 && req_crm == 12 &&
                req_op1 == 0 && req_op2 == 3;
      ok      = req_priv || user_en;
      e_valid = sel_ok;
      e_undef = sel_ok && !ok;
      e_rdata = (sel_ok && ok && !req_write) ? m_cnt : 32'h0;
      if (clr_in)                         m_cnt = 0;
      else if (sel_ok && ok && req_write) m_cnt = req_wdata;
      else if (evt_in)                    m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total += 3;
      if (rsp_valid !== e_valid) begin
        bad++; $display("FAIL %s rsp_valid act=%b exp=%b t=%0t", tag, rsp_valid, e_valid, $time);
      end
      if (rsp_undef !== e_undef) begin
        bad++; $display("FAIL %s rsp_undef act=%b exp=%b t=%0t", tag, rsp_undef, e_undef, $time);
      end
      if (rsp_rdata !== e_rdata) begin
        bad++; $display("FAIL %s rsp_rdata act=%h exp=%h t=%0t", tag, rsp_rdata, e_rdata, $time);
      end
    end
  end

  task automatic cyc(input bit v, input bit w, input logic [3:0] crn,
                     input logic [2:0] op1, input logic [3:0] crm,
                     input logic [2:0] op2, input logic [31:0] wd,
                     input bit pr, input bit ue, input bit ev, input bit cl);
    @(negedge clk); #1;
    req_valid = v; req_write = w; req_crn = crn; req_op1 = op1;
    req_crm = crm; req_op2 = op2; req_wdata = wd; req_priv = pr;
    user_en = ue; evt_in = ev; clr_in = cl;
  endtask

  task automatic rd(input bit pr, input bit ue);
    cyc(1, 0, 15, 0, 12, 3, 0, pr, ue, 0, 0);
  endtask
  task automatic wr(input logic [31:0] d, input bit pr, input bit ue);
    cyc(1, 1, 15, 0, 12, 3, d, pr, ue, 0, 0);
  endtask
  task automatic idle(input bit ev);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ev, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) idle(0);
    tag = "R7";  rd(1, 0); idle(0);
    tag = "R2";  repeat (5) idle(1); rd(1, 0); rd(1, 1); idle(0);
    tag = "R3";  wr(32'h1234_5678, 1, 0); rd(1, 0); idle(0);
    tag = "R4";  wr(32'hCAFE_0001, 0, 1); rd(0, 1); idle(1); rd(0, 1); idle(0);
    tag = "R5";  rd(0, 0); idle(0); rd(1, 0); idle(0);
    tag = "R6";  wr(32'hDEAD_BEEF, 0, 0); rd(1, 0); idle(0);
    tag = "R1";
    cyc(1, 1, 14, 0, 12, 3, 32'h11, 1, 0, 0, 0);
    cyc(1, 1, 15, 1, 12, 3, 32'h22, 1, 0, 0, 0);
    cyc(1, 1, 15, 0, 13, 3, 32'h33, 1, 0, 0, 0);
    cyc(1, 0, 15, 0, 12, 1, 32'h44, 0, 0, 0, 0);
    rd(1, 0); idle(0);
    tag = "R8";  wr(32'hFFFF_FFFE, 1, 0); repeat (3) idle(1); rd(1, 0); idle(0);
    tag = "R9";  repeat (4) idle(1); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); rd(1, 0); idle(0);
    tag = "R10";
    cyc(1, 1, 15, 0, 12, 3, 32'h0000_0100, 1, 0, 1, 0); rd(1, 0);
    cyc(1, 1, 15, 0, 12, 3, 32'h0000_0200, 1, 0, 1, 1); rd(1, 0); idle(0);
    tag = "R11";
    for (int i = 0; i < 300; i++) begin
      bit sel_hit;
      sel_hit = ($urandom % 3) != 0;
      cyc($urandom % 2, $urandom % 2, sel_hit ? 4'd15 : 4'($urandom),
          sel_hit ? 3'd0 : 3'($urandom), sel_hit ? 4'd12 : 4'($urandom),
          sel_hit ? 3'd3 : 3'($urandom), $urandom, $urandom % 2,
          $urandom % 2, $urandom % 2, ($urandom % 16) == 0);
    end
    idle(0); idle(0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule